// File: doc/BRIEF.md
# Programmable Pulse-Train Sequencer

The block turns a table of run-length instructions into a single clock output with cycle-exact timing. A host fills the table one 16-bit word at a time through a valid/ready write stream, then pulses a start strobe. Each pulse instruction holds the output high for a number of reference cycles, then low for another number, and repeats that pair a given number of times. Consecutive instructions follow each other with no idle cycle between them, so a long irregular clock pattern can be built from a short table.

An instruction whose repeat count is zero is a pause. The output stays low until a debounced edge on the external trigger input arrives, or until an optional timeout expires. Either way the sequencer then moves on to the next instruction. A table that starts with a pause with no timeout parks a secondary sequencer until the first trigger. The block reports finished and aborted flags, the number of output pulses produced and the running total of cycles spent paused. An abort strobe stops a run at once and forces the output low.

Write stream rules: a word is taken on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is low while a run is in progress and while the table is full. The host may hold `ld_valid` high with a stable word as long as it likes; nothing is lost while `ld_ready` is low.

Top module: `pulse_train_seq`

## Requirements
- R1: After reset the output is 0, both status bits are 0, both counters are 0 and `ld_ready` is 1.
- R2: An instruction is eight words in this order: high count bits 15:0, 31:16, 47:32, then low count bits 15:0, 31:16, 47:32, then repeat count bits 15:0, 31:16. Each completed group of eight is stored at the next table slot. `ld_ready` is 0 while a run is in progress and while DEPTH instructions are stored.
- R3: A pulse instruction (repeat count r > 0) drives the output high for exactly h cycles and low for exactly l cycles, r times over. Counts of 0 behave as 1. The first high cycle begins on the second clock edge after the edge that captures `start`.
- R4: Instructions run back to back without gap. After the last low cycle of the last instruction the output is 0 and status bit 0 (finished) is 1 from the next cycle on.
- R5: `sample_cnt` counts output rising edges since the last accepted start.
- R6: A pause instruction has repeat count 0. Bit 1 of its low-count field selects the trigger edge (1 = rising, 0 = falling) and bit 0 is written as 1. The output stays low during the pause. After a qualifying trigger change the output rises (if a pulse follows) on edge E+3+N, where E is the first clock edge that sees the new trigger level and N is `deb_ticks`.
- R7: A pause with a non-zero high-count field T ends by itself after T+1 cycles. A field of 0 means no timeout.
- R8: `wait_cnt` grows by one for every cycle spent in a pause, whether it ended on a trigger or on a timeout.
- R9: Trigger edges outside a pause, and in the first cycle of a pause, have no effect.
- R10: The debounced trigger level follows the synchronized input only after the two have differed for N+1 consecutive cycles, so shorter pulses are dropped.
- R11: `abort` stops the run and forces the output to 0 on the next edge, with status 2'b10 (bit 1 = aborted). An abort while idle also empties the table.
- R12: `start` is ignored while a run is in progress. An accepted start clears both counters and both status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Table write word is valid |
| ld_ready | output | 1 | Table write word can be taken |
| ld_word | input | 16 | Table write word |
| start | input | 1 | Start strobe, one cycle |
| abort | input | 1 | Abort strobe, one cycle |
| deb_ticks | input | 16 | Trigger debounce length N |
| trig_in | input | 1 | External trigger, asynchronous |
| clk_out | output | 1 | Generated clock output |
| status | output | 2 | Bit 0 finished, bit 1 aborted |
| sample_cnt | output | 32 | Output rising edges this run |
| wait_cnt | output | 32 | Total cycles spent in pauses this run |

## Verification
A wrong phase or repeat counter shows at once as a high or low stretch of the wrong length on `clk_out`, so the output is compared cycle by cycle against a waveform the bench builds from the table. A stale prefetch register shows at the first instruction boundary as a gap or a wrong pattern, and a bad table write pointer shows as a wrong pattern or an early finish. Faults in pause handling show as a wrong resume cycle after the trigger or the timeout, and as a wrong `wait_cnt` read once the run finishes.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int PH_W   = 48;
  localparam int REP_W  = 32;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic [REP_W-1:0] rep;
    logic [PH_W-1:0]  lo;
    logic [PH_W-1:0]  hi;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);
  localparam int WORDS_PER_INSTR = INSTR_W / WORD_W;

  typedef enum logic [2:0] {
    E_IDLE  = 3'd0,
    E_PRIME = 3'd1,
    E_HIGH  = 3'd2,
    E_LOW   = 3'd3,
    E_WAIT  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pts_loader.sv
module pts_loader
  import pts_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              clr,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WORD_W-1:0] ld_word,
  output logic [CW-1:0]     tbl_count,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output instr_t            rd_data
);
  localparam int WI_W = $clog2(WORDS_PER_INSTR);

  logic [INSTR_W-1:0] asm_q;
  logic [INSTR_W-1:0] asm_next;
  logic [WI_W-1:0]    widx;
  logic               fire;
  logic               last_word;
  instr_t             mem [DEPTH];

  assign ld_ready  = !busy && (tbl_count < CW'(DEPTH));
  assign fire      = ld_valid && ld_ready;
  assign last_word = (widx == WI_W'(WORDS_PER_INSTR - 1));
  assign asm_next  = {ld_word, asm_q[INSTR_W-1:WORD_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q     <= '0;
      widx      <= '0;
      tbl_count <= '0;
    end else if (clr) begin
      widx      <= '0;
      tbl_count <= '0;
    end else if (fire) begin
      asm_q <= asm_next;
      widx  <= last_word ? '0 : widx + WI_W'(1);
      if (last_word) tbl_count <= tbl_count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (fire && last_word && !clr) mem[tbl_count[AW-1:0]] <= instr_t'(asm_next);
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/pts_debounce.sv
module pts_debounce #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [TICK_W-1:0] ticks,
  output logic              rise,
  output logic              fall
);
  logic              sync1, sync2;
  logic              filt, filt_d;
  logic [TICK_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      filt   <= 1'b0;
      filt_d <= 1'b0;
      cnt    <= '0;
    end else begin
      sync1  <= trig_in;
      sync2  <= sync1;
      filt_d <= filt;
      if (sync2 == filt) begin
        cnt <= '0;
      end else if (cnt >= ticks) begin
        filt <= sync2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + TICK_W'(1);
      end
    end
  end

  assign rise = filt && !filt_d;
  assign fall = !filt && filt_d;
endmodule

// File: rtl/pts_engine.sv
module pts_engine
  import pts_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int CNT_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CW-1:0]    tbl_count,
  input  instr_t           rd_data,
  input  logic             trig_rise,
  input  logic             trig_fall,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             busy,
  output logic             clk_out,
  output logic             fin,
  output logic             abt,
  output logic [CNT_W-1:0] samples,
  output logic [CNT_W-1:0] wait_total
);
  seq_state_e       state;
  logic [CW-1:0]    pc;
  logic             nxt_vld;
  logic [PH_W-1:0]  ph_cnt, cur_hi, cur_lo;
  logic [REP_W-1:0] rep_cnt;
  logic [PH_W-1:0]  wt_cnt, wt_lim;
  logic             wt_rise;

  logic phase_last, rep_last, table_drained, ready_nxt;
  logic wait_hit, wait_expire, end_cond, boundary, take, finish;
  logic go, rise_ev;

  assign busy          = (state != E_IDLE);
  assign clk_out       = (state == E_HIGH);
  assign rd_addr       = pc[AW-1:0];
  assign go            = (state == E_IDLE) && start && !abort;
  assign phase_last    = (ph_cnt <= PH_W'(1));
  assign rep_last      = (rep_cnt <= REP_W'(1));
  assign table_drained = (pc >= tbl_count);
  assign ready_nxt     = nxt_vld || table_drained;
  assign wait_hit      = (wt_cnt != '0) && (wt_rise ? trig_rise : trig_fall);
  assign wait_expire   = (wt_lim != '0) && (wt_cnt >= wt_lim);

  always_comb begin
    case (state)
      E_PRIME: end_cond = 1'b1;
      E_LOW:   end_cond = phase_last && rep_last;
      E_WAIT:  end_cond = wait_hit || wait_expire;
      default: end_cond = 1'b0;
    endcase
  end

  assign boundary = end_cond && ready_nxt && !abort;
  assign take     = boundary && nxt_vld;
  assign finish   = boundary && !nxt_vld;
  assign rd_en    = busy && !abort && (!nxt_vld || take) && !table_drained;
  assign rise_ev  = (take && (rd_data.rep != '0)) ||
                    ((state == E_LOW) && phase_last && !rep_last && !abort);

  // prefetch slot: next instruction is read while the current one runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      nxt_vld <= 1'b0;
    end else if (abort || go) begin
      pc      <= '0;
      nxt_vld <= 1'b0;
    end else if (rd_en) begin
      pc      <= pc + CW'(1);
      nxt_vld <= 1'b1;
    end else if (take) begin
      nxt_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= E_IDLE;
      fin     <= 1'b0;
      abt     <= 1'b0;
      ph_cnt  <= '0;
      cur_hi  <= '0;
      cur_lo  <= '0;
      rep_cnt <= '0;
      wt_cnt  <= '0;
      wt_lim  <= '0;
      wt_rise <= 1'b0;
    end else if (abort) begin
      state <= E_IDLE;
      abt   <= 1'b1;
      fin   <= 1'b0;
    end else if (state == E_IDLE) begin
      if (start) begin
        state <= E_PRIME;
        fin   <= 1'b0;
        abt   <= 1'b0;
      end
    end else if (take) begin
      if (rd_data.rep == '0) begin
        state   <= E_WAIT;
        wt_cnt  <= '0;
        wt_lim  <= rd_data.hi;
        wt_rise <= rd_data.lo[1];
      end else begin
        state   <= E_HIGH;
        ph_cnt  <= rd_data.hi;
        cur_hi  <= rd_data.hi;
        cur_lo  <= rd_data.lo;
        rep_cnt <= rd_data.rep;
      end
    end else if (finish) begin
      state <= E_IDLE;
      fin   <= 1'b1;
    end else begin
      case (state)
        E_HIGH: begin
          if (phase_last) begin
            state  <= E_LOW;
            ph_cnt <= cur_lo;
          end else begin
            ph_cnt <= ph_cnt - PH_W'(1);
          end
        end
        E_LOW: begin
          if (!phase_last) begin
            ph_cnt <= ph_cnt - PH_W'(1);
          end else if (!rep_last) begin
            state   <= E_HIGH;
            ph_cnt  <= cur_hi;
            rep_cnt <= rep_cnt - REP_W'(1);
          end
        end
        E_WAIT: wt_cnt <= wt_cnt + PH_W'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samples    <= '0;
      wait_total <= '0;
    end else if (go) begin
      samples    <= '0;
      wait_total <= '0;
    end else if (!abort) begin
      if (state == E_WAIT) wait_total <= wait_total + CNT_W'(1);
      if (rise_ev) samples <= samples + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pulse_train_seq.sv
module pulse_train_seq
  import pts_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int CNT_W  = 32,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              start,
  input  logic              abort,
  input  logic [TICK_W-1:0] deb_ticks,
  input  logic              trig_in,
  output logic              clk_out,
  output logic [1:0]        status,
  output logic [CNT_W-1:0]  sample_cnt,
  output logic [CNT_W-1:0]  wait_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          busy, rd_en, trig_rise, trig_fall, fin, abt;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] tbl_count;
  instr_t        rd_data;

  pts_loader #(.DEPTH(DEPTH)) u_load (
    .clk(clk), .rst_n(rst_n), .busy(busy), .clr(abort && !busy),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_word(ld_word),
    .tbl_count(tbl_count), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  pts_debounce #(.TICK_W(TICK_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .ticks(deb_ticks),
    .rise(trig_rise), .fall(trig_fall)
  );

  pts_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .tbl_count(tbl_count), .rd_data(rd_data),
    .trig_rise(trig_rise), .trig_fall(trig_fall),
    .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .clk_out(clk_out),
    .fin(fin), .abt(abt), .samples(sample_cnt), .wait_total(wait_cnt)
  );

  assign status = {abt, fin};
endmodule

// File: rtl/pts_checker.sv
module pts_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             abort,
  input logic             clk_out,
  input logic             ld_ready,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] sample_cnt,
  input logic [CNT_W-1:0] wait_cnt
);
  p_no_load_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> !ld_ready);

  p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!clk_out && status == 2'b10));

  p_fin_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> !clk_out);

  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);

  p_sample_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> sample_cnt == $past(sample_cnt) + CNT_W'(1));

  p_sample_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(clk_out) && !$past(start)) |-> $stable(sample_cnt));

  p_no_wait_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |=> $stable(wait_cnt));
endmodule

bind pulse_train_seq pts_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .clk_out(clk_out),
  .ld_ready(ld_ready), .status(status), .sample_cnt(sample_cnt), .wait_cnt(wait_cnt)
);

// File: tb/pulse_train_seq_tb.sv
module pulse_train_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [15:0] ld_word = '0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [15:0] deb_ticks = 16'd1;
  logic        trig_in = 1'b0;
  logic        clk_out;
  logic [1:0]  status;
  logic [31:0] sample_cnt;
  logic [31:0] wait_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_w [512];
  int unsigned t_hi [8], t_lo [8], t_rep [8];

  pulse_train_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_word(ld_word), .start(start), .abort(abort), .deb_ticks(deb_ticks),
    .trig_in(trig_in), .clk_out(clk_out), .status(status),
    .sample_cnt(sample_cnt), .wait_cnt(wait_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2: word i of an instruction carries bits 16i+15:16i of {rep, lo, hi}
  task automatic load_instr(input longint unsigned hi, input longint unsigned lo,
                            input int unsigned rep);
    logic [127:0] v;
    v = {rep[31:0], lo[47:0], hi[47:0]};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_word  = v[16*i +: 16];
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  function automatic int build_exp(input int n);
    int idx = 2;
    for (int i = 0; i < 512; i++) exp_w[i] = 1'b0;
    for (int k = 0; k < n; k++)
      for (int r = 0; r < int'(t_rep[k]); r++) begin
        for (int h = 0; h < int'(t_hi[k]); h++) begin exp_w[idx] = 1'b1; idx++; end
        idx += int'(t_lo[k]);
      end
    return idx;
  endfunction

  function automatic int sum_reps(input int n);
    int s = 0;
    for (int k = 0; k < n; k++) s += int'(t_rep[k]);
    return s;
  endfunction

  task automatic run_random(input int tnum, input bit inject);
    int n, len, bad, rdy_bad;
    n = 1 + int'($urandom % 4);
    for (int k = 0; k < n; k++) begin
      t_hi[k]  = 1 + ($urandom % 5);
      t_lo[k]  = 1 + ($urandom % 5);
      t_rep[k] = 1 + ($urandom % 3);
    end
    pulse_abort();
    for (int k = 0; k < n; k++) load_instr(t_hi[k], t_lo[k], t_rep[k]);
    len = build_exp(n);
    bad = 0; rdy_bad = 0;
    pulse_start();
    for (int idx = 0; idx < len + 3; idx++) begin
      if (idx > 0) @(negedge clk);
      if (clk_out !== exp_w[idx]) bad++;
      if (idx < len && ld_ready !== 1'b0) rdy_bad++;
      if (inject) begin
        start   = (idx == 3);              // R12: start while running
        trig_in = ($urandom % 2) == 1;     // R9: trigger outside any pause
      end
    end
    start = 1'b0; trig_in = 1'b0;
    chk(bad == 0, $sformatf("R3 R4 R9 R12 waveform run %0d mismatches", tnum), bad, 0);
    chk(rdy_bad == 0, "R2 ld_ready low while running", rdy_bad, 0);
    chk(status == 2'b01, "R4 finished after last instruction", status, 1);
    chk(sample_cnt == 32'(sum_reps(n)), "R5 sample count", sample_cnt, sum_reps(n));
    repeat (8) @(negedge clk);
  endtask

  // R6 R8: trigger-resumed pause, sel = edge select bit
  task automatic run_trig(input int n_deb, input bit rising);
    int hi_at;
    deb_ticks = 16'(n_deb);
    pulse_abort();
    load_instr(0, rising ? 3 : 1, 0);
    load_instr(2, 2, 1);
    pulse_start();
    repeat (10) @(negedge clk);
    trig_in = rising;
    hi_at = 14 + n_deb;
    for (int idx = 11; idx <= hi_at; idx++) begin
      @(negedge clk);
      if (idx == hi_at - 1) chk(clk_out == 1'b0, "R6 low before resume", clk_out, 0);
      if (idx == hi_at)     chk(clk_out == 1'b1, "R6 resume after trigger", clk_out, 1);
    end
    repeat (6) @(negedge clk);
    chk(wait_cnt == 32'(12 + n_deb), "R8 wait cycles after trigger", wait_cnt, 12 + n_deb);
    chk(status == 2'b01, "R4 finished after pause run", status, 1);
  endtask

  initial begin
    int seen_high;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_out == 1'b0 && status == 2'b00, "R1 reset outputs", {clk_out, status}, 0);
    chk(sample_cnt == 0 && wait_cnt == 0, "R1 reset counters", sample_cnt + wait_cnt, 0);
    chk(ld_ready == 1'b1, "R1 ld_ready after reset", ld_ready, 1);

    // directed: fastest pattern, then two instructions back to back
    pulse_abort();
    t_hi[0] = 1; t_lo[0] = 1; t_rep[0] = 4;
    t_hi[1] = 3; t_lo[1] = 1; t_rep[1] = 1;
    load_instr(1, 1, 4); load_instr(3, 1, 1);
    begin
      int len, bad;
      len = build_exp(2); bad = 0;
      pulse_start();
      for (int idx = 0; idx < len + 2; idx++) begin
        if (idx > 0) @(negedge clk);
        if (clk_out !== exp_w[idx]) bad++;
      end
      chk(bad == 0, "R3 R4 directed back-to-back waveform", bad, 0);
      chk(sample_cnt == 5, "R5 directed sample count", sample_cnt, 5);
    end

    for (int t = 0; t < 6; t++) run_random(t, t >= 3);

    run_trig(2, 1'b1);
    run_trig(3, 1'b0);

    // R7 R10: short glitch dropped, pause ends on timeout field 30
    deb_ticks = 16'd4;
    pulse_abort();
    load_instr(30, 3, 0);
    load_instr(1, 1, 1);
    pulse_start();
    seen_high = 0;
    for (int idx = 1; idx <= 33; idx++) begin
      @(negedge clk);
      if (idx == 5) trig_in = 1'b1;
      if (idx == 7) trig_in = 1'b0;
      if (idx < 33 && clk_out) seen_high++;
      if (idx == 33) chk(clk_out == 1'b1, "R7 resume after timeout", clk_out, 1);
    end
    chk(seen_high == 0, "R10 glitch ignored", seen_high, 0);
    repeat (4) @(negedge clk);
    chk(wait_cnt == 32'd31, "R8 wait cycles after timeout", wait_cnt, 31);

    // R11: abort mid-pulse
    deb_ticks = 16'd1;
    pulse_abort();
    load_instr(50, 50, 2);
    pulse_start();
    repeat (5) @(negedge clk);
    chk(clk_out == 1'b1, "R3 long high phase", clk_out, 1);
    pulse_abort();
    chk(clk_out == 1'b0 && status == 2'b10, "R11 abort forces low", {clk_out, status}, 2);
    chk(ld_ready == 1'b1, "R11 idle after abort", ld_ready, 1);
    // R11: abort when idle empties table, run then ends at once
    pulse_abort();
    pulse_start();
    @(negedge clk);
    chk(status == 2'b01 && sample_cnt == 0, "R11 empty table finishes", status, 1);

    // R2: full table drops ld_ready
    for (int k = 0; k < DEPTH; k++) load_instr(1, 1, 1);
    chk(ld_ready == 1'b0, "R2 ld_ready low when table full", ld_ready, 0);
    pulse_abort();
    chk(ld_ready == 1'b1, "R11 table emptied", ld_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule